// File: doc/BRIEF.md
# SRAM Write-Hold Buffer with Read Forwarding

This block sits between an in-order request front end and a single-port, word-organised synchronous memory. Each accepted write is placed in a one-entry hold buffer, and the memory port stays free for whatever request comes next. A read takes the port in its own cycle. If the next request is another write, or if no request comes, the buffered write is committed to the array. As long as an unbroken run of reads follows a write, the write stays parked. The array is therefore updated later than the request order would suggest.

Reads never see stale data. A read whose word address matches the parked write still reads the array, because the array holds the bytes the write did not touch. The response stage then overlays the parked bytes on that array word and applies the read's own byte enables. Every request gets exactly one response, one cycle after it is accepted, in the order of acceptance. Writes are acknowledged with zero data.

Top module: `sram_hold_fwd`

## Requirements
- R1: Addressing is at word level. `mem_addr` equals `req_addr` with its two lowest bits removed, and those two bits never change which word is accessed.
- R2: In the cycle of a read request the memory port performs that read (`mem_en`=1, `mem_we`=0, `mem_addr` = the read's word address). A write accepted just before the read is not applied in that cycle.
- R3: A read to the word of a write not yet committed returns, for each byte enabled by the read, the written byte where that write's mask bit is 1 and the array byte otherwise.
- R4: A read to a word other than the parked one returns the array contents and is served before the parked write commits.
- R5: A parked write is committed (`mem_en`=1, `mem_we`=1, its word address, data and mask) in the first cycle after its acceptance that carries a write request or no request. Any number of reads in between keeps it parked.
- R6: In back-to-back writes, the earlier write is committed in the cycle of the later write's request, so each write uses its own port slot and request order is kept.
- R7: Byte-mask bit i enables data bits [8i+7:8i]. A write changes only the enabled bytes of the array, and `mem_wmask` carries the write's mask.
- R8: Every accepted request yields `rsp_valid` exactly one cycle later, and no response appears otherwise. Read data is masked by the read's byte enables, with disabled bytes returned as zero. A write response carries zero data.
- R9: After reset no write is pending: the port stays idle with no requests, and the first read returns plain array data.
- R10: The final array contents equal those of applying all writes in request order, whatever the mix of reads, writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle (always accepted) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte enables |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_rdata | output | DATA_W | Read data (zero for writes) |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write (else read) |
| mem_addr | output | ADDR_W-2 | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_wmask | output | DATA_W/8 | Memory byte write enables |
| mem_rdata | input | DATA_W | Memory read data, one cycle after a read |

## Verification
The bench pushes write-then-read pairs to the same word with partial masks. A design that lost forwarding would return the old bytes, and one that overlaid the whole held word would corrupt the bytes the write did not enable. It builds long runs of reads after a write, ending them with either a write or an idle cycle. Committing too early would steal a read's port slot, and never committing would leave the final array stale. Back-to-back writes to one word and to different words, with addresses whose low bits are nonzero, catch writes that are dropped or reordered and any use of the byte-offset bits in the word compare.

// File: rtl/sram_hold_pkg.sv
package sram_hold_pkg;
  typedef enum logic [1:0] {
    PORT_IDLE   = 2'd0,
    PORT_READ   = 2'd1,
    PORT_COMMIT = 2'd2
  } port_op_e;
endpackage

// File: rtl/whb_buffer.sv
module whb_buffer #(
  parameter int WAW = 10,
  parameter int DW  = 32,
  parameter int BW  = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           drain,
  input  logic [WAW-1:0] ld_addr,
  input  logic [DW-1:0]  ld_data,
  input  logic [BW-1:0]  ld_mask,
  input  logic [WAW-1:0] lk_addr,
  output logic           vld,
  output logic [WAW-1:0] addr,
  output logic [DW-1:0]  data,
  output logic [BW-1:0]  mask,
  output logic           hit
);
  logic           vld_d, vld_q;
  logic [WAW-1:0] addr_q;
  logic [DW-1:0]  data_q;
  logic [BW-1:0]  mask_q;

  always_comb begin
    vld_d = vld_q;
    if (drain) vld_d = 1'b0;
    if (load)  vld_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      mask_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (load) begin
        addr_q <= ld_addr;
        data_q <= ld_data;
        mask_q <= ld_mask;
      end
    end
  end

  assign vld  = vld_q;
  assign addr = addr_q;
  assign data = data_q;
  assign mask = mask_q;
  assign hit  = vld_q && (addr_q == lk_addr);

  // R5
  no_lost_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && vld_q) |-> drain);
endmodule

// File: rtl/whb_port_arb.sv
module whb_port_arb
  import sram_hold_pkg::*;
#(
  parameter int WAW = 10,
  parameter int DW  = 32,
  parameter int BW  = DW / 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_we,
  input  logic [WAW-1:0] req_waddr,
  input  logic           buf_vld,
  input  logic [WAW-1:0] buf_addr,
  input  logic [DW-1:0]  buf_data,
  input  logic [BW-1:0]  buf_mask,
  output logic           load,
  output logic           drain,
  output logic           mem_en,
  output logic           mem_we,
  output logic [WAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  output logic [BW-1:0]  mem_wmask
);
  port_op_e op;

  always_comb begin
    if (req_valid && !req_we) op = PORT_READ;
    else if (buf_vld)         op = PORT_COMMIT;
    else                      op = PORT_IDLE;
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    mem_wmask = '0;
    drain     = 1'b0;
    unique case (op)
      PORT_READ: begin
        mem_en   = 1'b1;
        mem_addr = req_waddr;
      end
      PORT_COMMIT: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = buf_addr;
        mem_wdata = buf_data;
        mem_wmask = buf_mask;
        drain     = 1'b1;
      end
      default: ;
    endcase
  end

  assign load = req_valid && req_we;

  // R2
  read_owns_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |-> (mem_en && !mem_we && mem_addr == req_waddr));
  // R9
  idle_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid && !buf_vld) |-> !mem_en);
endmodule

// File: rtl/whb_resp.sv
module whb_resp #(
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_read,
  input  logic [BW-1:0] acc_mask,
  input  logic          fwd_hit,
  input  logic [DW-1:0] fwd_data,
  input  logic [BW-1:0] fwd_mask,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);
  logic [DW-1:0] rbits_d, fbits_d;
  logic          vld_q, rd_q;
  logic [DW-1:0] rbits_q, fbits_q, fdata_q;

  for (genvar b = 0; b < BW; b++) begin : g_bytes
    assign rbits_d[8*b +: 8] = {8{acc_mask[b]}};
    assign fbits_d[8*b +: 8] = {8{fwd_hit & fwd_mask[b]}};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      rd_q    <= 1'b0;
      rbits_q <= '0;
      fbits_q <= '0;
      fdata_q <= '0;
    end else begin
      vld_q <= acc_valid;
      rd_q  <= acc_valid && acc_read;
      if (acc_valid && acc_read) begin
        rbits_q <= rbits_d;
        fbits_q <= fbits_d;
        fdata_q <= fwd_data;
      end
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_rdata = rd_q ? (((mem_rdata & ~fbits_q) | (fdata_q & fbits_q)) & rbits_q) : '0;

  // R8
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> rsp_valid);
  // R8
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !rsp_valid);
endmodule

// File: rtl/sram_hold_fwd.sv
module sram_hold_fwd #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_mask,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-3:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W/8-1:0] mem_wmask,
  input  logic [DATA_W-1:0]   mem_rdata
);
  localparam int WAW = ADDR_W - 2;
  localparam int BW  = DATA_W / 8;

  logic [WAW-1:0]    waddr;
  logic [1:0]        unused_lsb;
  logic              load, drain, buf_vld, buf_hit;
  logic [WAW-1:0]    buf_addr;
  logic [DATA_W-1:0] buf_data;
  logic [BW-1:0]     buf_mask;

  assign waddr      = req_addr[ADDR_W-1:2];
  assign unused_lsb = req_addr[1:0];

  whb_buffer #(.WAW(WAW), .DW(DATA_W), .BW(BW)) u_buf (
    .clk(clk), .rst_n(rst_n), .load(load), .drain(drain),
    .ld_addr(waddr), .ld_data(req_wdata), .ld_mask(req_mask),
    .lk_addr(waddr), .vld(buf_vld), .addr(buf_addr),
    .data(buf_data), .mask(buf_mask), .hit(buf_hit)
  );

  whb_port_arb #(.WAW(WAW), .DW(DATA_W), .BW(BW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_waddr(waddr), .buf_vld(buf_vld), .buf_addr(buf_addr),
    .buf_data(buf_data), .buf_mask(buf_mask), .load(load), .drain(drain),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wmask(mem_wmask)
  );

  whb_resp #(.DW(DATA_W), .BW(BW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .acc_valid(req_valid), .acc_read(!req_we),
    .acc_mask(req_mask), .fwd_hit(buf_hit), .fwd_data(buf_data),
    .fwd_mask(buf_mask), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // R6
  write_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_we) && req_valid && req_we) |->
      (mem_en && mem_we && mem_addr == $past(req_addr[ADDR_W-1:2])
       && mem_wdata == $past(req_wdata) && mem_wmask == $past(req_mask)));
  // R5
  idle_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid && req_we) && !req_valid) |->
      (mem_en && mem_we && mem_addr == $past(req_addr[ADDR_W-1:2])));
endmodule

// File: tb/test_sram_hold_fwd.sv
module test_sram_hold_fwd;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int WORDS = 1 << (AW - 2);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [3:0] req_mask = '0;
  logic rsp_valid, mem_en, mem_we;
  logic [DW-1:0] rsp_rdata, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-3:0] mem_addr;
  logic [3:0] mem_wmask;

  logic [DW-1:0] mem_arr [WORDS];
  logic [DW-1:0] ref_mem [WORDS];
  int n_checks = 0, n_errors = 0;
  logic exp_v;
  logic [DW-1:0] exp_d;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_hold_fwd #(.ADDR_W(AW), .DATA_W(DW)) i_sram_hold_fwd (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_wmask(mem_wmask), .mem_rdata(mem_rdata)
  );

  // single-port synchronous memory model
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin
        for (int b = 0; b < 4; b++)
          if (mem_wmask[b]) mem_arr[mem_addr][8*b +: 8] <= mem_wdata[8*b +: 8];
      end else begin
        mem_rdata <= mem_arr[mem_addr];
      end
    end
  end

  function automatic logic [DW-1:0] bits(input logic [3:0] m);
    logic [DW-1:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = {8{m[b]}};
    return r;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive one request (or idle) at a negedge and compute its expected response
  task automatic drive(input logic v, input logic we, input logic [AW-1:0] a,
                       input logic [DW-1:0] d, input logic [3:0] m);
    int w;
    w = int'(a >> 2);
    req_valid = v; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
    exp_v = v;
    exp_d = '0;
    if (v && we) ref_mem[w] = (ref_mem[w] & ~bits(m)) | (d & bits(m));
    else if (v) exp_d = ref_mem[w] & bits(m);
  endtask

  task automatic finish_step(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " rsp_valid (R8)"}, {31'd0, rsp_valid}, {31'd0, exp_v});
    if (exp_v) chk({tag, " rsp_rdata"}, rsp_rdata, exp_d);
  endtask

  task automatic step(input logic v, input logic we, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic [3:0] m, input string tag);
    drive(v, we, a, d, m);
    finish_step(tag);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    int seed_val;
    int mism;
    seed_val = $urandom(32'd7);
    for (int i = 0; i < WORDS; i++) begin
      mem_arr[i] = 32'hA5000000 ^ (i * 32'h00010203);
      ref_mem[i] = 32'hA5000000 ^ (i * 32'h00010203);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: idle after reset
    chk("R9 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
    chk("R9 mem_en idle after reset", {31'd0, mem_en}, 32'd0);
    @(negedge clk);
    step(1, 0, 12'h040, 0, 4'hF, "R9 first read plain array");

    // R1/R2: write with nonzero low bits, then read same word
    drive(1, 1, 12'h013, 32'h11223344, 4'b0010);
    finish_step("R7 write ack");
    drive(1, 0, 12'h010, 0, 4'hF);
    #1;
    chk("R2 read owns port", {30'd0, mem_en, mem_we}, {30'd0, 2'b10});
    chk("R1 word address of read", {22'd0, mem_addr}, 32'd4);
    finish_step("R3 forwarded merged read");
    drive(1, 0, 12'h020, 0, 4'hF);
    #1;
    chk("R4 other read on port", {22'd0, mem_addr}, 32'd8);
    finish_step("R4 other word array data");
    step(1, 0, 12'h012, 0, 4'b0011, "R3 partial read of held word");
    drive(0, 0, 0, 0, 0);
    #1;
    chk("R5 idle commit we", {30'd0, mem_en, mem_we}, {30'd0, 2'b11});
    chk("R5 idle commit addr", {22'd0, mem_addr}, 32'd4);
    chk("R7 commit mask", {28'd0, mem_wmask}, {28'd0, 4'b0010});
    finish_step("R5 idle");
    step(1, 0, 12'h011, 0, 4'hF, "R7 read after commit");

    // R6: back-to-back writes
    step(1, 1, 12'h030, 32'hDEADBEEF, 4'b1001, "R6 first write");
    drive(1, 1, 12'h034, 32'hCAFEF00D, 4'b0110);
    #1;
    chk("R6 first write committed in second slot", {21'd0, mem_we, mem_addr}, {21'd0, 1'b1, 10'd12});
    finish_step("R6 second write");
    step(1, 1, 12'h034, 32'h01020304, 4'b1000, "R6 same-word write");
    step(1, 0, 12'h034, 0, 4'hF, "R6 read sees both writes");
    step(1, 0, 12'h030, 0, 4'hF, "R6 read first word");

    // R10/R5: long run of reads after a write, ended by a write
    step(1, 1, 12'h050, 32'h55AA55AA, 4'b0101, "R5 park write");
    for (int k = 0; k < 5; k++)
      step(1, 0, 12'h050 | AW'(k % 4), 0, 4'(k + 3), "R5 read run keeps parked");
    step(1, 1, 12'h050, 32'h77777777, 4'b1010, "R5 write ends run");
    step(1, 0, 12'h050, 0, 4'hF, "R3 read after write-ended run");
    step(0, 0, 0, 0, 0, "R9 idle");

    // constrained random mix over a few words
    for (int n = 0; n < 4000; n++) begin
      logic v, we;
      logic [AW-1:0] a;
      v  = ($urandom % 8) != 0;
      we = $urandom % 2;
      a  = AW'((($urandom % 4) << 2) | ($urandom % 4));
      step(v, we, a, $urandom, 4'($urandom), "R10 random mix");
    end
    step(0, 0, 0, 0, 0, "R10 flush");
    step(0, 0, 0, 0, 0, "R10 flush");
    mism = 0;
    for (int i = 0; i < WORDS; i++) if (mem_arr[i] !== ref_mem[i]) mism++;
    chk("R10 final array mismatches", mism, 0);
    done = 1'b1;
    summary();
  end
endmodule